// File: doc/BRIEF.md
# PROM Operation and Retry Controller

This block runs one read or one program request against a 256-word PROM. A caller presents a 12-bit word address, an operation select and a start strobe. The address is range-checked first for both operations. A valid read needs no sequencing: the controller raises the read-data enable for one cycle, together with its completion flag. A program request also needs the programming supply to be present. The controller then launches single program cycles through a start/done handshake with a separate pulse sequencer. It samples a read-after-write compare bit after every cycle.

Programming is retried up to 49 attempts. When the compare first passes on attempt N, the controller runs 4N+5 more program cycles on the same word to reinforce it, and then reports success. If no attempt passes, the operation ends with a failure-to-program status. Each operation ends with exactly one status pulse that lasts one cycle.

Top module: `prom_op_ctrl`

## Requirements
- R1: A start whose address has any of bits 11:8 set ends, for either operation, with `addr_err_o` high in the cycle after the start was sampled. No program cycle is launched and `data_en_o` stays low. This check comes before the power check.
- R2: A read (`op_prog_i`=0) with an address in 0..255 raises `data_en_o` and `done_o` together, for one cycle, in the cycle after the start was sampled. A read does not depend on `pwr_ok_i`.
- R3: A program (`op_prog_i`=1) with a valid address and `pwr_ok_i` low ends with `hw_err_o` high in the cycle after the start. No program cycle is launched.
- R4: An accepted program raises `cyc_start_o` for one cycle in the cycle after the start. After each `cyc_done_i` that calls for another cycle, the next `cyc_start_o` comes in the following cycle. Two launches are never adjacent.
- R5: If `cmp_pass_i` is first high with `cyc_done_i` on attempt N (1-based, N ≤ 49), exactly 4N+5 further program cycles are launched. `done_o` then pulses, so the operation makes 5N+5 launches in total.
- R6: If 49 attempts all return `cmp_pass_i` low, `prog_fail_o` pulses after the 49th `cyc_done_i`, and exactly 49 cycles have been launched.
- R7: Of `done_o`, `addr_err_o`, `hw_err_o` and `prog_fail_o`, at most one is high in any cycle. Each ends an operation with a pulse one cycle long, in the cycle where `busy_o` is already low.
- R8: `busy_o` is high from the cycle after a program is accepted until its status cycle. A `start_i` seen while busy is ignored.
- R9: `data_en_o` is low in every cycle except the completion cycle of a valid read.
- R10: During the reinforcement cycles, the value of `cmp_pass_i` has no effect on the number of launches or on the final status.
- R11: While `rst_n` is low, and right after it rises, all outputs are low and the block is idle. A reset in the middle of a program abandons it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| op_prog_i | input | 1 | 1 = program request, 0 = read request |
| addr_i | input | 12 | Requested word address |
| pwr_ok_i | input | 1 | Programming supply present |
| cyc_start_o | output | 1 | Launch one program cycle (one-cycle pulse) |
| cyc_done_i | input | 1 | Sequencer finished the launched cycle (one-cycle pulse) |
| cmp_pass_i | input | 1 | Read-after-write compare result, valid with cyc_done_i |
| data_en_o | output | 1 | Return read data to the requester |
| done_o | output | 1 | Operation completed successfully |
| addr_err_o | output | 1 | Address out of range |
| hw_err_o | output | 1 | Programming supply missing |
| prog_fail_o | output | 1 | No attempt passed the compare |
| busy_o | output | 1 | A program operation is in progress |

## Verification
The assertions assume that the sequencer returns exactly one `cyc_done_i` pulse for each `cyc_start_o`. That pulse comes at least one cycle after the launch and never while the block is idle. They also assume that `cmp_pass_i` is read only in the cycle of `cyc_done_i`. The bench's sequencer model keeps to these rules. It answers each launch with a single done pulse two cycles later. It drives the compare bit from the chosen first-pass attempt, and toggles it during the reinforcement cycles so that R10 is exercised.

// File: rtl/prom_op_pkg.sv
package prom_op_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TRY    = 2'd1,
        ST_REPEAT = 2'd2
    } op_state_t;

    typedef struct packed {
        logic ok;
        logic addr_bad;
        logic pwr_bad;
        logic no_pass;
    } op_status_t;

endpackage

// File: rtl/prom_addr_chk.sv
module prom_addr_chk #(
    parameter int ADDR_W  = 12,
    parameter int WORD_AW = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_range_o
);
    generate
        if (ADDR_W > WORD_AW) begin : g_upper
            assign in_range_o = ~|addr_i[ADDR_W-1:WORD_AW];
        end else begin : g_full
            assign in_range_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/prom_retry_calc.sv
module prom_retry_calc #(
    parameter int MAX_ATT = 49,
    parameter int REP_MUL = 4,
    parameter int REP_ADD = 5,
    parameter int ATT_W   = 6,
    parameter int REP_W   = 8
) (
    input  logic [ATT_W-1:0] att_i,
    output logic             last_try_o,
    output logic [REP_W-1:0] rep_cnt_o
);
    assign last_try_o = (att_i >= ATT_W'(MAX_ATT));
    assign rep_cnt_o  = REP_W'(REP_MUL) * REP_W'(att_i) + REP_W'(REP_ADD);
endmodule

// File: rtl/prom_op_ctrl.sv
module prom_op_ctrl
    import prom_op_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int WORD_AW = 8,
    parameter int MAX_ATT = 49,
    parameter int REP_MUL = 4,
    parameter int REP_ADD = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_prog_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              pwr_ok_i,
    output logic              cyc_start_o,
    input  logic              cyc_done_i,
    input  logic              cmp_pass_i,
    output logic              data_en_o,
    output logic              done_o,
    output logic              addr_err_o,
    output logic              hw_err_o,
    output logic              prog_fail_o,
    output logic              busy_o
);
    localparam int ATT_W   = $clog2(MAX_ATT + 1);
    localparam int REP_MAX = REP_MUL * MAX_ATT + REP_ADD;
    localparam int REP_W   = $clog2(REP_MAX + 1);

    typedef struct packed {
        op_state_t        st;
        logic [ATT_W-1:0] att;
        logic [REP_W-1:0] rep;
        logic             cyc_start;
        logic             data_en;
        op_status_t       stat;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic             in_range;
    logic             last_try;
    logic [REP_W-1:0] rep_cnt;

    prom_addr_chk #(
        .ADDR_W (ADDR_W),
        .WORD_AW(WORD_AW)
    ) u_addr_chk (
        .addr_i    (addr_i),
        .in_range_o(in_range)
    );

    prom_retry_calc #(
        .MAX_ATT(MAX_ATT),
        .REP_MUL(REP_MUL),
        .REP_ADD(REP_ADD),
        .ATT_W  (ATT_W),
        .REP_W  (REP_W)
    ) u_retry_calc (
        .att_i     (c_q.att),
        .last_try_o(last_try),
        .rep_cnt_o (rep_cnt)
    );

    always_comb begin
        c_d           = c_q;
        c_d.cyc_start = 1'b0;
        c_d.data_en   = 1'b0;
        c_d.stat      = '0;
        case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (!in_range) begin
                        c_d.stat.addr_bad = 1'b1;
                    end else if (!op_prog_i) begin
                        c_d.data_en = 1'b1;
                        c_d.stat.ok = 1'b1;
                    end else if (!pwr_ok_i) begin
                        c_d.stat.pwr_bad = 1'b1;
                    end else begin
                        c_d.st        = ST_TRY;
                        c_d.att       = ATT_W'(1);
                        c_d.cyc_start = 1'b1;
                    end
                end
            end
            ST_TRY: begin
                if (cyc_done_i) begin
                    if (cmp_pass_i) begin
                        c_d.st        = ST_REPEAT;
                        c_d.rep       = rep_cnt;
                        c_d.cyc_start = 1'b1;
                    end else if (last_try) begin
                        c_d.st           = ST_IDLE;
                        c_d.stat.no_pass = 1'b1;
                    end else begin
                        c_d.att       = c_q.att + ATT_W'(1);
                        c_d.cyc_start = 1'b1;
                    end
                end
            end
            ST_REPEAT: begin
                if (cyc_done_i) begin
                    if (c_q.rep == REP_W'(1)) begin
                        c_d.st      = ST_IDLE;
                        c_d.stat.ok = 1'b1;
                    end else begin
                        c_d.rep       = c_q.rep - REP_W'(1);
                        c_d.cyc_start = 1'b1;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cyc_start_o = c_q.cyc_start;
    assign data_en_o   = c_q.data_en;
    assign done_o      = c_q.stat.ok;
    assign addr_err_o  = c_q.stat.addr_bad;
    assign hw_err_o    = c_q.stat.pwr_bad;
    assign prog_fail_o = c_q.stat.no_pass;
    assign busy_o      = (c_q.st != ST_IDLE);
endmodule

// File: rtl/prom_op_ctrl_chk.sv
module prom_op_ctrl_chk #(
    parameter int MAX_ATT = 49,
    parameter int REP_MUL = 4,
    parameter int REP_ADD = 5
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_start_o,
    input logic data_en_o,
    input logic done_o,
    input logic addr_err_o,
    input logic hw_err_o,
    input logic prog_fail_o,
    input logic busy_o
);
    localparam int TOTAL_MAX = (REP_MUL + 1) * MAX_ATT + REP_ADD;
    localparam int CW        = $clog2(TOTAL_MAX + 2);

    logic [CW-1:0] launch_q;
    logic          any_stat;

    assign any_stat = done_o | addr_err_o | hw_err_o | prog_fail_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launch_q <= '0;
        end else if (!busy_o) begin
            launch_q <= '0;
        end else if (cyc_start_o) begin
            launch_q <= launch_q + CW'(1);
        end
    end

    // R1
    addr_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err_o |-> (launch_q == '0) && !data_en_o);

    // R2
    read_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_en_o |-> done_o && !busy_o);

    // R3
    hw_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err_o |-> (launch_q == '0));

    // R4
    launch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |=> !cyc_start_o);

    // R4
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |-> busy_o);

    // R5
    reinforce_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && launch_q != '0) |->
            ((int'(launch_q) - REP_ADD) % (REP_MUL + 1) == 0) &&
            (int'(launch_q) >= REP_MUL + 1 + REP_ADD));

    // R6
    fail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fail_o |-> (int'(launch_q) == MAX_ATT));

    // R7
    one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, addr_err_o, hw_err_o, prog_fail_o}));

    // R7
    status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stat |-> !busy_o);
endmodule

bind prom_op_ctrl prom_op_ctrl_chk #(
    .MAX_ATT(MAX_ATT),
    .REP_MUL(REP_MUL),
    .REP_ADD(REP_ADD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start_o(cyc_start_o),
    .data_en_o  (data_en_o),
    .done_o     (done_o),
    .addr_err_o (addr_err_o),
    .hw_err_o   (hw_err_o),
    .prog_fail_o(prog_fail_o),
    .busy_o     (busy_o)
);

// File: tb/prom_op_ctrl_bench.sv
`timescale 1ns/1ps
module prom_op_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_prog_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic        pwr_ok_i = 1'b0;
    logic        cyc_start_o;
    logic        cyc_done_i = 1'b0;
    logic        cmp_pass_i = 1'b0;
    logic        data_en_o, done_o, addr_err_o, hw_err_o, prog_fail_o, busy_o;

    int checks = 0;
    int fails = 0;
    int launches = 0;
    int pass_at = 0;
    int del = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    prom_op_ctrl u_prom_op_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_prog_i(op_prog_i),
        .addr_i(addr_i), .pwr_ok_i(pwr_ok_i), .cyc_start_o(cyc_start_o),
        .cyc_done_i(cyc_done_i), .cmp_pass_i(cmp_pass_i), .data_en_o(data_en_o),
        .done_o(done_o), .addr_err_o(addr_err_o), .hw_err_o(hw_err_o),
        .prog_fail_o(prog_fail_o), .busy_o(busy_o)
    );

    // vector: {prog, addr[11:0], pwr, pass_at[5:0], code[1:0]}
    // code: 0 done, 1 address error, 2 hardware error, 3 program failure
    localparam int NV = 9;
    localparam logic [21:0] VECS [NV] = '{
        {1'b0, 12'h000, 1'b0, 6'd0,  2'd0},
        {1'b0, 12'h0FF, 1'b1, 6'd0,  2'd0},
        {1'b0, 12'h100, 1'b1, 6'd0,  2'd1},
        {1'b1, 12'h800, 1'b0, 6'd1,  2'd1},
        {1'b1, 12'h0A5, 1'b0, 6'd1,  2'd2},
        {1'b1, 12'h012, 1'b1, 6'd1,  2'd0},
        {1'b1, 12'h0FF, 1'b1, 6'd3,  2'd0},
        {1'b1, 12'h001, 1'b1, 6'd49, 2'd0},
        {1'b1, 12'h040, 1'b1, 6'd0,  2'd3}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int stat_code();
        if (done_o)      return 0;
        if (addr_err_o)  return 1;
        if (hw_err_o)    return 2;
        if (prog_fail_o) return 3;
        return 7;
    endfunction

    function automatic int exp_launch(input bit prog, input int code, input int pa);
        if (prog && code == 0) return pa + 4 * pa + 5;
        if (code == 3)         return 49;
        return 0;
    endfunction

    // sequencer model: one done pulse two cycles after each launch
    initial begin
        forever begin
            @(negedge clk);
            if (del == 1) begin
                cyc_done_i = 1'b1;
                if (pass_at != 0 && launches == pass_at)     cmp_pass_i = 1'b1;
                else if (pass_at != 0 && launches > pass_at) cmp_pass_i = launches[0];
                else                                         cmp_pass_i = 1'b0;
                del = 0;
            end else begin
                cyc_done_i = 1'b0;
                cmp_pass_i = 1'b0;
                if (del > 1) del--;
            end
            if (cyc_start_o) begin
                launches++;
                del = 2;
            end
        end
    end

    int bad_de = 0;
    int bad_multi = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && data_en_o && !done_o) bad_de++;
            if (rst_n && (int'(done_o) + int'(addr_err_o) + int'(hw_err_o) + int'(prog_fail_o)) > 1)
                bad_multi++;
        end
    end

    task automatic pulse_start(input bit prog, input logic [11:0] a, input bit pwr);
        @(negedge clk);
        start_i = 1'b1; op_prog_i = prog; addr_i = a; pwr_ok_i = pwr;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_status(output int code, output int lat);
        lat = 1;
        while (stat_code() == 7 && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        code = stat_code();
    endtask

    task automatic run_vec(input logic [21:0] v);
        bit prog; int pa; int code; int lat; int ec; int de;
        prog = v[21]; pa = int'(v[7:2]); ec = int'(v[1:0]);
        pass_at = pa; launches = 0;
        pulse_start(prog, v[20:9], v[8]);
        wait_status(code, lat);
        de = int'(data_en_o);
        chk(code == ec, (ec == 1) ? "R1" : (ec == 2) ? "R3" : (ec == 3) ? "R6" : (prog ? "R5" : "R2"),
            "status code", code, ec);
        chk(launches == exp_launch(prog, ec, pa), prog ? "R5/R6 launches" : "R1 launches",
            "launch count", launches, exp_launch(prog, ec, pa));
        chk(de == int'(!prog && ec == 0), "R9", "data enable at status", de, int'(!prog && ec == 0));
        if (ec == 1 || ec == 2 || !prog)
            chk(lat == 1, "R2 latency", "status latency", lat, 1);
        @(negedge clk);
        chk(stat_code() == 7 && !data_en_o, "R7", "status pulse length", stat_code(), 7);
    endtask

    initial begin
        int code; int lat;
        repeat (3) @(negedge clk);
        chk(!cyc_start_o && !data_en_o && stat_code() == 7 && !busy_o, "R11",
            "outputs in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && stat_code() == 7, "R11", "idle after reset", int'(busy_o), 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R8: start while busy is ignored; R10 repetition compare toggles
        pass_at = 2; launches = 0;
        pulse_start(1'b1, 12'h010, 1'b1);
        chk(busy_o == 1'b1, "R8", "busy after accept", int'(busy_o), 1);
        repeat (5) @(negedge clk);
        pulse_start(1'b0, 12'h300, 1'b1);
        wait_status(code, lat);
        chk(code == 0, "R8", "status after ignored start", code, 0);
        chk(launches == 15, "R10", "launches with toggling compare", launches, 15);
        chk(!busy_o, "R8", "busy low at status", int'(busy_o), 0);

        // R11: reset mid-program abandons it
        pass_at = 0; launches = 0;
        pulse_start(1'b1, 12'h020, 1'b1);
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy_o && !cyc_start_o && stat_code() == 7, "R11", "reset mid program",
            int'(busy_o), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(!busy_o && stat_code() == 7, "R11", "stays idle after reset", int'(busy_o), 0);

        // R4: first launch one cycle after start
        pass_at = 1; launches = 0;
        pulse_start(1'b1, 12'h033, 1'b1);
        chk(launches == 1, "R4", "first launch timing", launches, 1);
        wait_status(code, lat);
        chk(code == 0 && launches == 10, "R4", "program completes", launches, 10);

        chk(bad_de == 0, "R9", "data enable outside read completion", bad_de, 0);
        chk(bad_multi == 0, "R7", "multiple status flags", bad_multi, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule